// File: doc/BRIEF.md
# Vector Integer Add/Subtract Lane Array

This block performs element-wise integer addition and subtraction on two vector source operands for a SIMD vector processor. A decoded six-bit operation code and the mask-enable bit select the operation. The choices are a plain add or subtract, an unsigned or signed widening add or subtract, an add with carry-in or a subtract with borrow-in taken from the mask operand, and a carry-out or borrow-out written back as a packed bit mask. The element width is 8, 16, 32 or 64 bits. The count of active elements sets which elements are written. The previous destination contents enter as an input, and every element the operation does not write keeps its old value.

Operands enter through a valid/ready handshake. A transfer happens on a rising clock edge when `in_valid` and `in_ready` are both high. The result is registered, so it appears on the output one cycle after acceptance. The output side has its own valid/ready pair. While `out_valid` is high and `out_ready` is low, the output is frozen and `in_ready` drops, so back-pressure reaches the producer in the same cycle. The producer may leave `in_valid` high while the block stalls. The destination is `2*VLEN` bits wide so that a widening result fits. Non-widening forms touch only the lower `VLEN` bits.

Top module: `vas_top`

## Requirements
- R1: With `in_vm`=1, op 6'b000000 writes element i as (vs2[i] + vs1[i]) mod 2^SEW and op 6'b000010 writes (vs2[i] - vs1[i]) mod 2^SEW. Bits `VLEN` and above of `out_vd` equal those of `in_vd_old`.
- R2: `in_sew` codes 0, 1, 2 and 3 select SEW = 8, 16, 32 and 64. Source element i occupies bits [i*SEW +: SEW], and non-widening results are placed the same way.
- R3: Ops 6'b110000 (add) and 6'b110010 (subtract) zero-extend both operands to 2*SEW. Result element i occupies bits [i*2*SEW +: 2*SEW] of `out_vd`.
- R4: Ops 6'b110001 (add) and 6'b110011 (subtract) sign-extend both operands to 2*SEW. Result placement is the same as in R3.
- R5: With `in_vm`=0, op 6'b010000 writes vs2[i] + vs1[i] + v0[i] and op 6'b010010 writes vs2[i] - vs1[i] - v0[i], both mod 2^SEW. Every element below vl is written whatever its mask bit.
- R6: Op 6'b010001 sets bit i of `out_vd` to the carry out of vs2[i] + vs1[i] + c. Op 6'b010011 sets it to the borrow out of vs2[i] - vs1[i] - c. Here c = v0[i] when `in_vm`=0 and c = 0 when `in_vm`=1. All other bits keep their old values.
- R7: With `in_vm`=0, ops 6'b000000, 6'b000010 and the four widening codes write element i only when bit i of `in_v0` is 1. Other elements keep their old values.
- R8: Elements with index i >= `in_vl` are unchanged. With `in_vl`=0 the whole output equals `in_vd_old`.
- R9: The following are illegal: a widening op at SEW=64, op 6'b010000 or 6'b010010 with `in_vm`=1, and any code not listed above. An illegal op sets `out_illegal` and returns `in_vd_old` unchanged. Legal ops clear `out_illegal`.
- R10: `in_ready` = !`out_valid` || `out_ready`. An accepted input produces `out_valid` on the next cycle. While `out_valid` && !`out_ready`, `out_vd` and `out_illegal` hold.
- R11: During and right after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid |
| in_ready | output | 1 | Block can accept operands |
| in_funct6 | input | 6 | Operation code |
| in_vm | input | 1 | 1 = mask unused, 0 = mask operand used |
| in_sew | input | 2 | Element width code |
| in_vl | input | 5 | Number of active elements |
| in_vs2 | input | VLEN | First source vector |
| in_vs1 | input | VLEN | Second source vector |
| in_v0 | input | VLEN/8 | Mask / carry-in bits, bit i for element i |
| in_vd_old | input | 2*VLEN | Previous destination contents |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_vd | output | 2*VLEN | Destination result |
| out_illegal | output | 1 | Operation was illegal |

## Verification
The assertions assume three things about the inputs: reset is applied before the first transfer, `out_ready` is a plain level, and the operands are meaningful only in cycles where `in_valid` and `in_ready` are both high. The stall and acceptance properties rely on nothing else about the producer. The stimulus keeps `in_vl` within 0 to 17, which includes values above the element count at wide SEW. It holds a stalled offer unchanged until it is accepted. It toggles `out_ready` randomly, so acceptance happens both while the output is stalled and while it drains.

// File: rtl/vas_pkg.sv
package vas_pkg;

  // Width codes for the element size selector
  typedef enum logic [1:0] {
    SEW_8  = 2'd0,
    SEW_16 = 2'd1,
    SEW_32 = 2'd2,
    SEW_64 = 2'd3
  } sew_e;

  // Operation codes
  localparam logic [5:0] F6_ADD   = 6'b000000;
  localparam logic [5:0] F6_SUB   = 6'b000010;
  localparam logic [5:0] F6_WADDU = 6'b110000;
  localparam logic [5:0] F6_WSUBU = 6'b110010;
  localparam logic [5:0] F6_WADD  = 6'b110001;
  localparam logic [5:0] F6_WSUB  = 6'b110011;
  localparam logic [5:0] F6_ADC   = 6'b010000;
  localparam logic [5:0] F6_MADC  = 6'b010001;
  localparam logic [5:0] F6_SBC   = 6'b010010;
  localparam logic [5:0] F6_MSBC  = 6'b010011;

  // Decoded control for the lane array
  typedef struct packed {
    logic sub;        // subtract instead of add
    logic widen;      // 2*SEW result
    logic sext;       // sign-extend on widening
    logic mask_out;   // write carry/borrow bits
    logic use_mask;   // v0 gates element writes
    logic use_cin;    // v0 supplies carry/borrow in
    logic illegal;
  } vas_ctl_t;

endpackage

// File: rtl/vas_decode.sv
module vas_decode
  import vas_pkg::*;
(
  input  logic [5:0] funct6,
  input  logic       vm,
  input  logic [1:0] sew,
  output vas_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    unique case (funct6)
      F6_ADD: ctl.use_mask = ~vm;
      F6_SUB: begin
        ctl.sub      = 1'b1;
        ctl.use_mask = ~vm;
      end
      F6_WADDU, F6_WSUBU, F6_WADD, F6_WSUB: begin
        ctl.widen    = 1'b1;
        ctl.sub      = funct6[1];
        ctl.sext     = funct6[0];
        ctl.use_mask = ~vm;
        ctl.illegal  = (sew == SEW_64);
      end
      F6_ADC, F6_SBC: begin
        ctl.sub     = funct6[1];
        ctl.use_cin = 1'b1;
        ctl.illegal = vm;
      end
      F6_MADC, F6_MSBC: begin
        ctl.sub      = funct6[1];
        ctl.mask_out = 1'b1;
        ctl.use_cin  = ~vm;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/vas_lanes.sv
module vas_lanes
  import vas_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NMAX = VLEN / 8,
  localparam int VLW  = $clog2(NMAX + 1)
) (
  input  vas_ctl_t              ctl,
  input  logic [1:0]            sew,
  input  logic [VLW-1:0]        vl,
  input  logic [VLEN-1:0]       vs2,
  input  logic [VLEN-1:0]       vs1,
  input  logic [NMAX-1:0]       v0,
  input  logic [2*VLEN-1:0]     vd_old,
  output logic [2*VLEN-1:0]     res
);

  logic [2*VLEN-1:0] per_sew [4];

  for (genvar k = 0; k < 4; k++) begin : g_sew
    localparam int W = 8 << k;
    localparam int N = VLEN / W;

    always_comb begin
      logic [W-1:0]   a, b;
      logic [W:0]     s;
      logic [2*W-1:0] wa, wb;
      logic           act, cin;
      per_sew[k] = vd_old;
      for (int i = 0; i < N; i++) begin
        a   = vs2[i*W +: W];
        b   = vs1[i*W +: W];
        act = (VLW'(i) < vl);
        cin = ctl.use_cin & v0[i];
        s   = ctl.sub ? ({1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin})
                      : ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin});
        wa  = {{W{ctl.sext & a[W-1]}}, a};
        wb  = {{W{ctl.sext & b[W-1]}}, b};
        if (act && !ctl.illegal) begin
          if (ctl.mask_out) begin
            per_sew[k][i] = s[W];
          end else if (!ctl.use_mask || v0[i]) begin
            if (ctl.widen)
              per_sew[k][i*2*W +: 2*W] = ctl.sub ? (wa - wb) : (wa + wb);
            else
              per_sew[k][i*W +: W] = s[W-1:0];
          end
        end
      end
    end
  end

  assign res = per_sew[sew];

endmodule

// File: rtl/vas_top.sv
module vas_top
  import vas_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NMAX = VLEN / 8,
  localparam int VLW  = $clog2(NMAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [5:0]          in_funct6,
  input  logic                in_vm,
  input  logic [1:0]          in_sew,
  input  logic [VLW-1:0]      in_vl,
  input  logic [VLEN-1:0]     in_vs2,
  input  logic [VLEN-1:0]     in_vs1,
  input  logic [NMAX-1:0]     in_v0,
  input  logic [2*VLEN-1:0]   in_vd_old,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*VLEN-1:0]   out_vd,
  output logic                out_illegal
);

  vas_ctl_t          ctl;
  logic [2*VLEN-1:0] lane_res;
  logic              take;

  vas_decode u_dec (
    .funct6 (in_funct6),
    .vm     (in_vm),
    .sew    (in_sew),
    .ctl    (ctl)
  );

  vas_lanes #(.VLEN(VLEN)) u_lanes (
    .ctl    (ctl),
    .sew    (in_sew),
    .vl     (in_vl),
    .vs2    (in_vs2),
    .vs1    (in_vs1),
    .v0     (in_v0),
    .vd_old (in_vd_old),
    .res    (lane_res)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_vd      <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_vd      <= lane_res;
        out_illegal <= ctl.illegal;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vas_chk.sv
module vas_chk #(
  parameter int VLEN = 128,
  localparam int NMAX = VLEN / 8,
  localparam int VLW  = $clog2(NMAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [5:0]        in_funct6,
  input logic [1:0]        in_sew,
  input logic [VLW-1:0]    in_vl,
  input logic [2*VLEN-1:0] in_vd_old,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2*VLEN-1:0] out_vd,
  input logic              out_illegal
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vd) && $stable(out_illegal)); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10

  AST_VL_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_vl == '0 |=> out_vd == $past(in_vd_old)); // R8

  AST_WIDE64_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_funct6[5:4] == 2'b11 && in_sew == 2'd3 |=> out_illegal); // R9

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_illegal || out_vd == $past(in_vd_old)); // R9

endmodule

bind vas_top vas_chk #(.VLEN(VLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_funct6   (in_funct6),
  .in_sew      (in_sew),
  .in_vl       (in_vl),
  .in_vd_old   (in_vd_old),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_vd      (out_vd),
  .out_illegal (out_illegal)
);

// File: tb/tb_vas_top.sv
module tb_vas_top;
  localparam int VLEN = 128;
  localparam int NMAX = VLEN / 8;
  localparam int VLW  = $clog2(NMAX + 1);
  localparam int NCYC = 8000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [5:0]        in_funct6;
  logic              in_vm;
  logic [1:0]        in_sew;
  logic [VLW-1:0]    in_vl;
  logic [VLEN-1:0]   in_vs2, in_vs1;
  logic [NMAX-1:0]   in_v0;
  logic [2*VLEN-1:0] in_vd_old;
  logic              out_valid;
  logic              out_ready;
  logic [2*VLEN-1:0] out_vd;
  logic              out_illegal;

  always #2.5 clk = ~clk;

  vas_top #(.VLEN(VLEN)) dut (.*);

  typedef struct {
    logic [5:0]        f6;
    logic              vm;
    logic [1:0]        sew;
    logic [VLW-1:0]    vl;
    logic [VLEN-1:0]   vs2, vs1;
    logic [NMAX-1:0]   v0;
    logic [2*VLEN-1:0] old;
  } tx_t;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  tx_t dq[$];

  task automatic check(input bit ok, input string req, input logic [2*VLEN-1:0] act,
                       input logic [2*VLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_ill(tx_t t);
    case (t.f6)
      6'b000000, 6'b000010, 6'b010001, 6'b010011: return 0;
      6'b110000, 6'b110010, 6'b110001, 6'b110011: return t.sew == 2'd3; // R9
      6'b010000, 6'b010010: return t.vm;                                 // R9
      default: return 1;
    endcase
  endfunction

  // Behavioural model: R1 R2 R3 R4 R5 R6 R7 R8
  function automatic logic [2*VLEN-1:0] ref_vd(tx_t t);
    logic [2*VLEN-1:0] r = t.old;
    int w = 8 << t.sew;
    int n = VLEN / w;
    if (ref_ill(t)) return r;
    for (int i = 0; i < n; i++) begin
      logic [128:0] a = 0, b = 0, v;
      logic m = t.v0[i];
      if (i >= int'(t.vl)) continue;
      for (int j = 0; j < w; j++) begin a[j] = t.vs2[i*w+j]; b[j] = t.vs1[i*w+j]; end
      case (t.f6)
        6'b000000, 6'b000010: begin
          if (!t.vm && !m) continue;
          v = (t.f6 == 6'b000000) ? a + b : a - b;
          for (int j = 0; j < w; j++) r[i*w+j] = v[j];
        end
        6'b110000, 6'b110010, 6'b110001, 6'b110011: begin
          if (!t.vm && !m) continue;
          if (t.f6[0] && a[w-1]) a = a - (129'd1 << w);
          if (t.f6[0] && b[w-1]) b = b - (129'd1 << w);
          v = t.f6[1] ? a - b : a + b;
          for (int j = 0; j < 2*w; j++) r[i*2*w+j] = v[j];
        end
        6'b010000: begin v = a + b + m; for (int j = 0; j < w; j++) r[i*w+j] = v[j]; end
        6'b010010: begin v = a - b - m; for (int j = 0; j < w; j++) r[i*w+j] = v[j]; end
        6'b010001: begin v = a + b + (t.vm ? 0 : m); r[i] = v[w]; end
        6'b010011: r[i] = (a < b + (t.vm ? 129'd0 : 129'(m)));
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic string req_of(tx_t t);
    string s;
    if (ref_ill(t)) return "R9";
    case (t.f6)
      6'b000000, 6'b000010: s = t.vm ? "R1" : "R7";
      6'b110000, 6'b110010: s = "R3";
      6'b110001, 6'b110011: s = "R4";
      6'b010000, 6'b010010: s = "R5";
      default:              s = "R6";
    endcase
    s = {s, " R2 sew=", $sformatf("%0d", t.sew)};
    if (int'(t.vl) < VLEN / (8 << t.sew)) s = {s, " R8"};
    return s;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic tx_t rnd_tx();
    tx_t t;
    logic [5:0] ops [11] = '{6'b000000, 6'b000010, 6'b110000, 6'b110010, 6'b110001,
                             6'b110011, 6'b010000, 6'b010001, 6'b010010, 6'b010011, 6'b000001};
    t.f6  = ops[$urandom_range(0, 10)];
    t.vm  = $urandom_range(0, 1);
    if ((t.f6 == 6'b010000 || t.f6 == 6'b010010) && $urandom_range(0, 7) != 0) t.vm = 0;
    t.sew = 2'($urandom_range(0, 3));
    t.vl  = VLW'($urandom_range(0, 17));
    t.vs2 = rnd_vec();
    t.vs1 = rnd_vec();
    t.v0  = NMAX'($urandom);
    t.old = {rnd_vec(), rnd_vec()};
    return t;
  endfunction

  // Directed: every code at every width with all-ones / zero boundaries
  task automatic build_directed();
    logic [5:0] ops [11] = '{6'b000000, 6'b000010, 6'b110000, 6'b110010, 6'b110001,
                             6'b110011, 6'b010000, 6'b010001, 6'b010010, 6'b010011, 6'b000001};
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 11; o++)
        for (int p = 0; p < 6; p++) begin
          tx_t t = rnd_tx();
          t.f6  = ops[o];
          t.sew = 2'(s);
          t.vs2 = (p < 2) ? '1 : (p < 4) ? '0 : rnd_vec();
          t.vs1 = (p % 2 == 1) ? '1 : '0;
          t.v0  = (p < 3) ? '1 : 16'hA5C3;
          t.vm  = (p % 3 == 2);
          t.vl  = (p == 5) ? VLW'(0) : (p == 4) ? VLW'(3) : VLW'(16);
          dq.push_back(t);
        end
  endtask

  initial begin : watchdog
    repeat (NCYC + 200) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    tx_t cur;
    bit  holding = 0;
    bit  m_valid = 0;
    bit  m_ill = 0;
    logic [2*VLEN-1:0] m_vd = '0;
    string m_req = "";
    in_valid = 0; out_ready = 0; in_funct6 = 0; in_vm = 1; in_sew = 0; in_vl = 0;
    in_vs2 = 0; in_vs1 = 0; in_v0 = 0; in_vd_old = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R11 reset out_valid", {255'd0, out_valid}, '0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 after reset", {255'd0, out_valid}, '0);
    build_directed();
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      check(out_valid === m_valid, "R10 out_valid", {255'd0, out_valid}, {255'd0, m_valid});
      if (m_valid) begin
        check(out_vd === m_vd, m_req, out_vd, m_vd);
        check(out_illegal === m_ill, {m_req, " R9 flag"}, {255'd0, out_illegal}, {255'd0, m_ill});
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (!holding) begin
        if ($urandom_range(0, 4) != 0) begin
          cur = (dq.size() > 0) ? dq.pop_front() : rnd_tx();
          in_valid = 1;
        end else in_valid = 0;
      end
      in_funct6 = cur.f6; in_vm = cur.vm; in_sew = cur.sew; in_vl = cur.vl;
      in_vs2 = cur.vs2; in_vs1 = cur.vs1; in_v0 = cur.v0; in_vd_old = cur.old;
      #1;
      check(in_ready === (!m_valid || out_ready), "R10 in_ready",
            {255'd0, in_ready}, {255'd0, (!m_valid || out_ready)});
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid = 1; m_vd = ref_vd(cur); m_ill = ref_ill(cur); m_req = req_of(cur);
        holding = 0;
      end else begin
        if (out_ready) m_valid = 0;
        holding = in_valid;
      end
      @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule